// File: doc/BRIEF.md
# Eight-Input Interrupt Priority Resolver

This block keeps three 8-bit registers for eight interrupt lines: the pending-request register, the mask register and the in-service register. From the pending, unmasked requests it picks the winner under the current priority order. When that winner may preempt the levels already in service, it raises the interrupt output. On an acknowledge strobe it moves the winner from pending to in-service and returns an 8-bit vector. That vector is a 5-bit base followed by the 3-bit level number.

A command decoder outside the block supplies the static configuration: trigger style, automatic end-of-interrupt and vector base. It also sends single-cycle command pulses for mask writes, end-of-interrupt commands and special-mask-mode changes. An end-of-interrupt can clear the highest-priority in-service level or one named level. Either kind can also rotate the priority, so that the cleared level becomes the lowest. The bus interface and cascade addressing are outside this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When `cfg_level`=0, a request bit is set by a 0-to-1 change on its line and cleared when that level is acknowledged; a line that stays high does not set it again. When `cfg_level`=1, each request bit follows its line, registered one cycle later.
- R2: A line whose `imr_out` bit is 1 still sets its `irr_out` bit, but it never causes `int_out` or an acknowledge of that level.
- R3: One cycle after `inta`, `vec_valid` is 1 and `vec_out` = {`cfg_vec_base`[4:0], level[2:0]}; for example, base 5'h08 with level 5 gives 8'h45.
- R4: After reset the priority is fixed: level 0 is highest and level 7 is lowest. An acknowledge sets the winner's `isr_out` bit and clears its `irr_out` bit.
- R5: With special mask mode off, `int_out` is 1 only if the winning request has strictly higher priority than every level set in `isr_out`.
- R6: A pulse on `eoi_cmd` with `eoi_specific`=0 clears the highest-priority bit set in `isr_out`.
- R7: A pulse on `eoi_cmd` with `eoi_specific`=1 clears the `isr_out` bit selected by `eoi_level`.
- R8: When `eoi_rotate`=1 with an EOI, the cleared level becomes the lowest priority and the level after it, wrapping modulo 8, becomes the highest.
- R9: When `cfg_auto_eoi`=1, an acknowledge leaves `isr_out` unchanged, so no EOI is needed.
- R10: A pulse on `smm_wr` loads `smm_val` into special mask mode. While that mode is on, in-service levels do not block other levels, but a level that is itself in service is not requested again.
- R11: An acknowledge while `int_out` is 0 returns the spurious vector {base, 3'd7} and changes neither `isr_out` nor `irr_out`.
- R12: A synchronous reset clears `irr_out`, `isr_out`, `imr_out` and `int_out`, turns special mask mode off and restores fixed priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 8 | Raw interrupt lines |
| cfg_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| cfg_auto_eoi | input | 1 | 1 = automatic end-of-interrupt on acknowledge |
| cfg_vec_base | input | 5 | Upper five bits of the vector |
| mask_wr | input | 1 | Pulse: load `mask_data` into the mask register |
| mask_data | input | 8 | New mask, 1 = level blocked |
| eoi_cmd | input | 1 | Pulse: end-of-interrupt command |
| eoi_specific | input | 1 | 1 = clear the level given by `eoi_level` |
| eoi_rotate | input | 1 | 1 = cleared level becomes the lowest priority |
| eoi_level | input | 3 | Level for a specific EOI |
| smm_wr | input | 1 | Pulse: load special mask mode |
| smm_val | input | 1 | New special mask mode value |
| inta | input | 1 | Acknowledge strobe, one cycle |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned on acknowledge |
| vec_valid | output | 1 | `vec_out` is valid this cycle |
| irr_out | output | 8 | Pending-request register |
| isr_out | output | 8 | In-service register |
| imr_out | output | 8 | Mask register |

## Verification
The bench uses the package defaults: eight levels, a 3-bit level field and a 5-bit base. These sizes make every level, the wrap of the rotation pointer and the spurious level 7 reachable in a few cycles. Directed sequences cover several cases:
- nesting of two levels,
- both EOI kinds,
- rotation reordering two pending levels,
- automatic EOI,
- special mask mode,
- a level request that disappears before acknowledge.

Seeded random masks and line patterns then compare the interrupt output and the acknowledge vector against a priority model written in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
    parameter int IRQ_N  = 8;
    parameter int LVL_W  = $clog2(IRQ_N);
    parameter int VEC_W  = 8;
    parameter int BASE_W = VEC_W - LVL_W;

    typedef logic [IRQ_N-1:0] irq_vec_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } pick_t;

    typedef struct packed {
        logic valid;
        logic specific;
        logic rotate;
        lvl_t lvl;
    } eoi_req_t;

    // rank 0 is the highest priority; lowest holds the level with least priority
    function automatic lvl_t rank_of(lvl_t lvl, lvl_t lowest);
        return lvl - lowest - lvl_t'(1);
    endfunction

    function automatic irq_vec_t lvl_bit(lvl_t lvl);
        return irq_vec_t'(1) << lvl;
    endfunction

    // highest-priority set bit of v under the rotation given by lowest
    function automatic pick_t pick_top(irq_vec_t v, lvl_t lowest);
        pick_t r;
        lvl_t  idx;
        r = '0;
        for (int k = IRQ_N - 1; k >= 0; k--) begin
            idx = lowest + lvl_t'(1) + lvl_t'(k);
            if (v[idx]) begin
                r.hit = 1'b1;
                r.lvl = idx;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_req_reg.sv
module irq_req_reg
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t irq_in,
    input  logic     cfg_level,
    input  irq_vec_t ack_clr,
    output irq_vec_t irr_q
);
    irq_vec_t irq_d;
    irq_vec_t rise;

    assign rise = irq_in & ~irq_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_d <= '0;
            irr_q <= '0;
        end else begin
            irq_d <= irq_in;
            if (cfg_level)
                irr_q <= irq_in;
            else
                irr_q <= (irr_q & ~ack_clr) | rise;
        end
    end

    for (genvar i = 0; i < IRQ_N; i++) begin : g_chk
        AST_EDGE_SETS_REQ: assert property (@(posedge clk) disable iff (rst)
            (!cfg_level && irq_in[i] && !irq_d[i]) |=> irr_q[i]); // R1
    end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_pkg::*;
(
    input  irq_vec_t irr,
    input  irq_vec_t imr,
    input  irq_vec_t isr,
    input  logic     smm,
    input  lvl_t     lowest,
    output logic     int_req,
    output lvl_t     win_lvl
);
    irq_vec_t eligible;
    pick_t    cand;
    pick_t    top_isr;
    logic     beats_isr;

    always_comb begin
        eligible  = irr & ~imr & (smm ? ~isr : '1);
        cand      = pick_top(eligible, lowest);
        top_isr   = pick_top(isr, lowest);
        beats_isr = !top_isr.hit ||
                    (rank_of(cand.lvl, lowest) < rank_of(top_isr.lvl, lowest));
        int_req   = cand.hit && (smm || beats_isr);
        win_lvl   = cand.lvl;
    end
endmodule

// File: rtl/irq_isr_ctrl.sv
module irq_isr_ctrl
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ack_take,
    input  lvl_t     ack_lvl,
    input  logic     auto_eoi,
    input  eoi_req_t eoi,
    output irq_vec_t isr_q,
    output lvl_t     lowest_q
);
    pick_t    top;
    logic     eoi_hit;
    lvl_t     eoi_lvl;
    irq_vec_t clr;
    irq_vec_t set;

    always_comb begin
        top     = pick_top(isr_q, lowest_q);
        eoi_hit = eoi.valid && (eoi.specific || top.hit);
        eoi_lvl = eoi.specific ? eoi.lvl : top.lvl;
        clr     = eoi_hit ? lvl_bit(eoi_lvl) : '0;
        set     = (ack_take && !auto_eoi) ? lvl_bit(ack_lvl) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q    <= '0;
            lowest_q <= lvl_t'(IRQ_N - 1);
        end else begin
            isr_q <= (isr_q & ~clr) | set;
            if (eoi_hit && eoi.rotate)
                lowest_q <= eoi_lvl;
        end
    end

    AST_ACK_TO_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !auto_eoi) |=> isr_q[$past(ack_lvl)]); // R4
    AST_AUTO_EOI_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ack_take && auto_eoi && !eoi.valid) |=> (isr_q == $past(isr_q))); // R9
    AST_SPEC_EOI_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (eoi.valid && eoi.specific && !(ack_take && !auto_eoi && ack_lvl == eoi.lvl))
        |=> !isr_q[$past(eoi.lvl)]); // R7
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IRQ_N-1:0]  irq_in,
    input  logic              cfg_level,
    input  logic              cfg_auto_eoi,
    input  logic [BASE_W-1:0] cfg_vec_base,
    input  logic              mask_wr,
    input  logic [IRQ_N-1:0]  mask_data,
    input  logic              eoi_cmd,
    input  logic              eoi_specific,
    input  logic              eoi_rotate,
    input  logic [LVL_W-1:0]  eoi_level,
    input  logic              smm_wr,
    input  logic              smm_val,
    input  logic              inta,
    output logic              int_out,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid,
    output logic [IRQ_N-1:0]  irr_out,
    output logic [IRQ_N-1:0]  isr_out,
    output logic [IRQ_N-1:0]  imr_out
);
    localparam lvl_t SPURIOUS_LVL = lvl_t'(IRQ_N - 1);

    irq_vec_t imr_q;
    logic     smm_q;
    irq_vec_t irr_q;
    irq_vec_t isr_q;
    lvl_t     lowest_q;
    logic     int_req;
    lvl_t     win_lvl;
    logic     ack_take;
    irq_vec_t ack_clr;
    eoi_req_t eoi;

    assign ack_take = inta && int_req;
    assign ack_clr  = ack_take ? lvl_bit(win_lvl) : '0;
    assign eoi      = '{valid: eoi_cmd, specific: eoi_specific,
                        rotate: eoi_rotate, lvl: eoi_level};

    irq_req_reg u_req (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_level(cfg_level),
        .ack_clr(ack_clr), .irr_q(irr_q)
    );

    irq_prio_resolve u_res (
        .irr(irr_q), .imr(imr_q), .isr(isr_q), .smm(smm_q), .lowest(lowest_q),
        .int_req(int_req), .win_lvl(win_lvl)
    );

    irq_isr_ctrl u_isr (
        .clk(clk), .rst(rst), .ack_take(ack_take), .ack_lvl(win_lvl),
        .auto_eoi(cfg_auto_eoi), .eoi(eoi), .isr_q(isr_q), .lowest_q(lowest_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            imr_q     <= '0;
            smm_q     <= 1'b0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            if (mask_wr)
                imr_q <= mask_data;
            if (smm_wr)
                smm_q <= smm_val;
            vec_valid <= inta;
            if (inta)
                vec_out <= {cfg_vec_base, ack_take ? win_lvl : SPURIOUS_LVL};
        end
    end

    assign int_out = int_req;
    assign irr_out = irr_q;
    assign isr_out = isr_q;
    assign imr_out = imr_q;

    AST_MASK_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (|(irr_q & ~imr_q))); // R2
    AST_VEC_FORMAT: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_out[VEC_W-1:LVL_W] == $past(cfg_vec_base))); // R3
    AST_SPURIOUS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (inta && !int_req && !eoi_cmd) |=> (isr_out == $past(isr_out))); // R11
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       cfg_level = 1'b0, cfg_auto_eoi = 1'b0;
    logic [4:0] cfg_vec_base = 5'h08;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_data = '0;
    logic       eoi_cmd = 1'b0, eoi_specific = 1'b0, eoi_rotate = 1'b0;
    logic [2:0] eoi_level = '0;
    logic       smm_wr = 1'b0, smm_val = 1'b0, inta = 1'b0;
    logic       int_out, vec_valid;
    logic [7:0] vec_out, irr_out, isr_out, imr_out;

    int total = 0, bad = 0;
    bit done = 1'b0;

    irq_prio_ctrl dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_level(cfg_level),
        .cfg_auto_eoi(cfg_auto_eoi), .cfg_vec_base(cfg_vec_base),
        .mask_wr(mask_wr), .mask_data(mask_data), .eoi_cmd(eoi_cmd),
        .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate),
        .eoi_level(eoi_level), .smm_wr(smm_wr), .smm_val(smm_val),
        .inta(inta), .int_out(int_out), .vec_out(vec_out),
        .vec_valid(vec_valid), .irr_out(irr_out), .isr_out(isr_out),
        .imr_out(imr_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_in = '0; tick(); rst = 1'b0;
    endtask

    task automatic ack();
        inta = 1'b1; tick(); inta = 1'b0;
    endtask

    task automatic eoi(bit spec, bit rot, logic [2:0] lvl);
        eoi_cmd = 1'b1; eoi_specific = spec; eoi_rotate = rot; eoi_level = lvl;
        tick();
        eoi_cmd = 1'b0; eoi_specific = 1'b0; eoi_rotate = 1'b0;
    endtask

    task automatic set_mask(logic [7:0] m);
        mask_wr = 1'b1; mask_data = m; tick(); mask_wr = 1'b0;
    endtask

    // fixed-priority model: lowest set index, -1 when none
    function automatic int ref_pick(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] ref_vec(logic [4:0] base, int lvl);
        return {base, (lvl < 0) ? 3'd7 : lvl[2:0]};
    endfunction

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        check("R12 irr", irr_out, 0);
        check("R12 isr", isr_out, 0);
        check("R12 imr", imr_out, 0);
        check("R12 int", int_out, 0);

        // nesting and vector
        irq_in[5] = 1'b1; tick();
        check("R1 edge sets", irr_out, 8'h20);
        check("R4 int", int_out, 1);
        ack();
        check("R3 valid", vec_valid, 1);
        check("R3 vec", vec_out, 8'h45);
        check("R4 isr", isr_out, 8'h20);
        check("R1 held line no reset", irr_out, 8'h00);
        irq_in[6] = 1'b1; tick();
        check("R5 lower blocked", int_out, 0);
        irq_in[2] = 1'b1; tick();
        check("R5 higher preempts", int_out, 1);
        ack();
        check("R3 vec nest", vec_out, 8'h42);
        check("R4 isr nest", isr_out, 8'h24);
        eoi(1'b0, 1'b0, 3'd0);
        check("R6 nonspecific", isr_out, 8'h20);
        check("R5 still blocked", int_out, 0);
        eoi(1'b1, 1'b0, 3'd5);
        check("R7 specific", isr_out, 8'h00);
        check("R5 released", int_out, 1);
        ack();
        check("R3 vec 6", vec_out, 8'h46);
        eoi(1'b0, 1'b0, 3'd0);
        irq_in = '0; tick();

        // masking
        set_mask(8'h08);
        irq_in[3] = 1'b1; tick();
        check("R2 recorded", irr_out, 8'h08);
        check("R2 no int", int_out, 0);
        set_mask(8'h00);
        check("R2 unmasked int", int_out, 1);
        ack();
        check("R2 vec", vec_out, 8'h43);
        eoi(1'b0, 1'b0, 3'd0);
        irq_in = '0; tick();

        // level mode and spurious
        cfg_level = 1'b1;
        irq_in[4] = 1'b1; tick();
        check("R1 level follows", irr_out, 8'h10);
        irq_in[4] = 1'b0; tick();
        check("R1 level drops", irr_out, 8'h00);
        ack();
        check("R11 spurious vec", vec_out, 8'h47);
        check("R11 isr kept", isr_out, 8'h00);
        check("R11 irr kept", irr_out, 8'h00);
        cfg_level = 1'b0;

        // rotation
        do_reset();
        irq_in = 8'h03; tick();
        ack();
        check("R4 fixed 0 first", vec_out, 8'h40);
        eoi(1'b0, 1'b1, 3'd0);
        irq_in[0] = 1'b0; tick();
        irq_in[0] = 1'b1; tick();
        check("R8 both pending", irr_out, 8'h03);
        ack();
        check("R8 rotated winner", vec_out, 8'h41);

        // automatic EOI
        do_reset();
        cfg_auto_eoi = 1'b1;
        irq_in[3] = 1'b1; tick();
        ack();
        check("R9 vec", vec_out, 8'h43);
        check("R9 no isr", isr_out, 8'h00);
        cfg_auto_eoi = 1'b0;

        // special mask mode
        do_reset();
        irq_in[2] = 1'b1; tick();
        ack();
        irq_in[6] = 1'b1; tick();
        check("R5 blocked before smm", int_out, 0);
        smm_wr = 1'b1; smm_val = 1'b1; tick(); smm_wr = 1'b0;
        check("R10 lower allowed", int_out, 1);
        ack();
        check("R10 vec", vec_out, 8'h46);
        check("R10 isr", isr_out, 8'h44);
        irq_in[2] = 1'b0; tick();
        irq_in[2] = 1'b1; tick();
        check("R10 own level held", int_out, 0);

        // random fixed-priority patterns
        for (int it = 0; it < 150; it++) begin
            logic [7:0] m, l;
            logic [4:0] b;
            int w;
            do_reset();
            m = 8'($urandom); l = 8'($urandom); b = 5'($urandom);
            cfg_vec_base = b;
            set_mask(m);
            irq_in = l; tick();
            w = ref_pick(l & ~m);
            check("R1 random irr", irr_out, l);
            check("R2 random int", int_out, (w >= 0));
            ack();
            check("R3 random vec", vec_out, ref_vec(b, w));
            check("R4 random isr", isr_out, (w >= 0) ? (8'h01 << w) : 8'h00);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule